// File: doc/BRIEF.md
# Serial avionics word transmitter with eight-word queue

The block turns 31-bit avionics data words, delivered as two 16-bit halves from a parallel bus, into a self-clocking return-to-zero serial stream on two line outputs. One line pulses for each one bit and the other pulses for each zero bit. A bit 32 is appended as a parity bit. Odd or even parity is chosen by a control input. Up to eight complete words wait in a first-in first-out queue. A ready flag tells the host that the queue has drained and the line has gone quiet.

The line rate comes from the master clock divided by 10 (fast) or by 80 (slow). The divided clock is also driven out. Every bit takes one divided-clock period: the data half comes first and a null half follows. Consecutive words are separated by a gap of four bit times. Two loopback pairs give the stream in true and in swapped (complemented) polarity, so that on-chip receivers can be fed for self-test.

Top module: `a429_tx_fifo`

## Requirements
- R1: `tx_clk_o` has a period of 10 master clocks when `div_slow_i`=0 and 80 when it is 1. It is high for the first half of each period, starting from reset.
- R2: A pulse on `ld_lo_i` latches `bus_i[15:0]` as word bits 1..16, with bit 1 = `bus_i[0]`. A later pulse on `ld_hi_i` appends `bus_i[14:0]` as bits 17..31 and queues the word. `bus_i[15]` is ignored on the high half, and an `ld_hi_i` with no pending low half is ignored.
- R3: The queue holds at most 8 words. A word offered while all 8 slots are occupied is dropped, and the stored words are unaffected.
- R4: `ready_o` is high only when the queue is empty and no word or word gap is in progress. It falls in the cycle after a word is queued.
- R5: With words queued and the line idle, transmission starts at the first divided-clock boundary after `tx_en_i` is high. Bit 1 appears within one divided-clock period.
- R6: Each bit drives its line only during the first half of its divided-clock period. Both lines are low in the second half and for 4 full periods after bit 32.
- R7: Bit 32 makes the total number of ones in the 32 bits odd when `par_even_i`=0 and even when it is 1. The setting is taken when the word starts.
- R8: A one bit raises `line_one_o` and a zero bit raises `line_zero_o`. The two lines are never high together. Bits are sent in order from bit 1 to bit 32.
- R9: Asserting `rst_ni` low stops the line at once, empties the queue, drops any pending low half and sets `ready_o`.
- R10: If `tx_en_i` falls during a word, that word and its gap complete, and no further queued word is started.
- R11: `lb_true_o` equals {`line_one_o`, `line_zero_o`} and `lb_comp_o` equals {`line_zero_o`, `line_one_o`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_slow_i | input | 1 | Line rate select: 0 divides by 10, 1 divides by 80 |
| par_even_i | input | 1 | Parity select: 0 odd, 1 even |
| tx_en_i | input | 1 | Transmit enable |
| bus_i | input | 16 | Parallel data half |
| ld_lo_i | input | 1 | Latch strobe for the low half (bits 1..16) |
| ld_hi_i | input | 1 | Strobe for the high half (bits 17..31); queues the word |
| line_one_o | output | 1 | Return-to-zero pulse for one bits |
| line_zero_o | output | 1 | Return-to-zero pulse for zero bits |
| tx_clk_o | output | 1 | Divided data clock |
| ready_o | output | 1 | Queue empty and line idle |
| lb_true_o | output | 2 | Loopback pair, true polarity {one, zero} |
| lb_comp_o | output | 2 | Loopback pair, complemented polarity {zero, one} |

## Verification
The hardest states to reach are a queue that is full while the serializer is busy, and an enable that drops in the middle of a word. The stimulus reaches the first by holding `tx_en_i` low and offering nine words, then enabling and counting the bits decoded at the lines. It reaches the second by loading three words, enabling, and removing the enable about ten bit times into the first word. A mid-word reset is also applied while queued words remain, and the bench then checks that nothing more is sent.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEND = 2'd1,
        SQ_GAP  = 2'd2
    } sq_state_e;

    // Parity bit for a frame whose data-bit ones count has parity odd_sum.
    function automatic logic frame_parity(input logic odd_sum, input logic even_mode);
        return even_mode ? odd_sum : ~odd_sum;
    endfunction

endpackage

// File: rtl/a429_bitclk.sv
module a429_bitclk #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic slow_i,
    output logic tick_o,
    output logic first_half_o
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CNT_W   = $clog2(DIV_MAX);
    localparam logic [CNT_W-1:0] LAST_F = CNT_W'(DIV_FAST - 1);
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(DIV_SLOW - 1);
    localparam logic [CNT_W-1:0] HALF_F = CNT_W'(DIV_FAST / 2);
    localparam logic [CNT_W-1:0] HALF_S = CNT_W'(DIV_SLOW / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_s_t;

    div_s_t s_q, s_d;
    logic   tick;

    always_comb begin
        s_d          = s_q;
        tick         = (s_q.cnt >= (slow_i ? LAST_S : LAST_F));
        s_d.cnt      = tick ? '0 : s_q.cnt + CNT_W'(1);
        first_half_o = (s_q.cnt < (slow_i ? HALF_S : HALF_F));
        tick_o       = tick;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

endmodule

// File: rtl/a429_wfifo.sv
module a429_wfifo #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 31,
    parameter int BUS_W  = 16
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [BUS_W-1:0]                  bus_i,
    input  logic                              ld_lo_i,
    input  logic                              ld_hi_i,
    input  logic                              pop_i,
    output logic [WORD_W-1:0]                 head_o,
    output logic [$clog2(DEPTH+1)-1:0]        count_o,
    output logic                              empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HI_W  = WORD_W - BUS_W;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
        logic [BUS_W-1:0]             lo;
        logic                         pend;
    } fifo_s_t;

    fifo_s_t          s_q, s_d;
    logic             do_push;
    logic             do_pop;
    logic [WORD_W-1:0] word_in;
    logic [DEPTH-1:0] slot_we;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            assign slot_we[g] = do_push && (s_q.wr == PTR_W'(g));
        end
        if (HI_W < BUS_W) begin : g_spare
            logic unused_bus_top;
            assign unused_bus_top = ^bus_i[BUS_W-1:HI_W];
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        do_push = ld_hi_i && s_q.pend && (s_q.cnt != CNT_FULL);
        do_pop  = pop_i && (s_q.cnt != '0);
        word_in = {bus_i[HI_W-1:0], s_q.lo};

        if (ld_lo_i) begin
            s_d.lo   = bus_i;
            s_d.pend = 1'b1;
        end else if (ld_hi_i) begin
            s_d.pend = 1'b0;
        end

        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) s_d.mem[i] = word_in;
        end

        if (do_push) s_d.wr = bump(s_q.wr);
        if (do_pop)  s_d.rd = bump(s_q.rd);

        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase

        head_o  = s_q.mem[s_q.rd];
        count_o = s_q.cnt;
        empty_o = (s_q.cnt == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

endmodule

// File: rtl/a429_serial.sv
module a429_serial
    import a429_tx_pkg::*;
#(
    parameter int WORD_W   = 31,
    parameter int GAP_BITS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              first_half_i,
    input  logic              tx_en_i,
    input  logic              has_word_i,
    input  logic              par_even_i,
    input  logic [WORD_W-1:0] head_i,
    output logic              pop_o,
    output logic              line_one_o,
    output logic              line_zero_o,
    output logic              idle_o
);
    localparam int FRAME_W = WORD_W + 1;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int GAP_W   = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_BITS - 1);

    typedef struct packed {
        sq_state_e          state;
        logic [FRAME_W-1:0] sh;
        logic [BIT_W-1:0]   bitn;
        logic [GAP_W-1:0]   gap;
    } ser_s_t;

    ser_s_t s_q, s_d;
    logic   may_start;
    logic   sending;

    always_comb begin
        s_d       = s_q;
        may_start = tick_i && tx_en_i && has_word_i &&
                    ((s_q.state == SQ_IDLE) ||
                     ((s_q.state == SQ_GAP) && (s_q.gap == LAST_GAP)));

        if (tick_i) begin
            case (s_q.state)
                SQ_SEND: begin
                    if (s_q.bitn == LAST_BIT) begin
                        s_d.state = SQ_GAP;
                        s_d.gap   = '0;
                    end else begin
                        s_d.bitn = s_q.bitn + BIT_W'(1);
                        s_d.sh   = {1'b0, s_q.sh[FRAME_W-1:1]};
                    end
                end
                SQ_GAP: begin
                    if (s_q.gap == LAST_GAP) s_d.state = SQ_IDLE;
                    else                     s_d.gap   = s_q.gap + GAP_W'(1);
                end
                default: ;
            endcase
        end

        if (may_start) begin
            s_d.state = SQ_SEND;
            s_d.sh    = {frame_parity(^head_i, par_even_i), head_i};
            s_d.bitn  = '0;
        end

        sending     = (s_q.state == SQ_SEND);
        pop_o       = may_start;
        line_one_o  = sending && first_half_i && s_q.sh[0];
        line_zero_o = sending && first_half_i && !s_q.sh[0];
        idle_o      = (s_q.state == SQ_IDLE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{state: SQ_IDLE, default: '0};
        else         s_q <= s_d;
    end

endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
    parameter int DEPTH    = 8,
    parameter int WORD_W   = 31,
    parameter int BUS_W    = 16,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             div_slow_i,
    input  logic             par_even_i,
    input  logic             tx_en_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic             ld_lo_i,
    input  logic             ld_hi_i,
    output logic             line_one_o,
    output logic             line_zero_o,
    output logic             tx_clk_o,
    output logic             ready_o,
    output logic [1:0]       lb_true_o,
    output logic [1:0]       lb_comp_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              tick;
    logic              first_half;
    logic              pop;
    logic              empty;
    logic              idle;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;

    a429_bitclk #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_clk (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slow_i       (div_slow_i),
        .tick_o       (tick),
        .first_half_o (first_half)
    );

    a429_wfifo #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W),
        .BUS_W  (BUS_W)
    ) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .bus_i   (bus_i),
        .ld_lo_i (ld_lo_i),
        .ld_hi_i (ld_hi_i),
        .pop_i   (pop),
        .head_o  (head),
        .count_o (fifo_cnt),
        .empty_o (empty)
    );

    a429_serial #(
        .WORD_W   (WORD_W),
        .GAP_BITS (GAP_BITS)
    ) u_ser (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .first_half_i (first_half),
        .tx_en_i      (tx_en_i),
        .has_word_i   (!empty),
        .par_even_i   (par_even_i),
        .head_i       (head),
        .pop_o        (pop),
        .line_one_o   (line_one_o),
        .line_zero_o  (line_zero_o),
        .idle_o       (idle)
    );

    assign tx_clk_o  = first_half;
    assign ready_o   = empty && idle;
    assign lb_true_o = {line_one_o, line_zero_o};
    assign lb_comp_o = {line_zero_o, line_one_o};

endmodule

// File: rtl/a429_tx_fifo_chk.sv
module a429_tx_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             line_one,
    input logic             line_zero,
    input logic             tx_clk,
    input logic             ready,
    input logic [CNT_W-1:0] fifo_cnt
);
    // R8
    a_r8_lines_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(line_one && line_zero));

    // R6
    a_r6_null_half_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tx_clk |-> !(line_one || line_zero));

    // R4
    a_r4_ready_line_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready |-> !(line_one || line_zero));

    // R3
    a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_cnt <= CNT_W'(DEPTH));

    // R3
    a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, fifo_cnt} <= ({1'b0, $past(fifo_cnt)} + (CNT_W+1)'(1))));

    // R4
    a_r4_ready_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready |-> (fifo_cnt == '0));

endmodule

bind a429_tx_fifo a429_tx_fifo_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_one  (line_one_o),
    .line_zero (line_zero_o),
    .tx_clk    (tx_clk_o),
    .ready     (ready_o),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/a429_tx_fifo_test.sv
module a429_tx_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_slow = 1'b0;
    logic        par_even = 1'b0;
    logic        tx_en = 1'b0;
    logic [15:0] bus = '0;
    logic        ld_lo = 1'b0;
    logic        ld_hi = 1'b0;
    logic        line_one, line_zero, tx_clk, ready;
    logic [1:0]  lb_true, lb_comp;

    always #5 clk = ~clk;

    a429_tx_fifo uut (
        .clk_i(clk), .rst_ni(rst_n), .div_slow_i(div_slow), .par_even_i(par_even),
        .tx_en_i(tx_en), .bus_i(bus), .ld_lo_i(ld_lo), .ld_hi_i(ld_hi),
        .line_one_o(line_one), .line_zero_o(line_zero), .tx_clk_o(tx_clk),
        .ready_o(ready), .lb_true_o(lb_true), .lb_comp_o(lb_comp)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [30:0] q[$];
    int          md = 0;      // 0 idle, 1 sending, 2 gap
    int          bn = 0;
    int          gp = 0;
    int          dv = 0;
    logic [31:0] cur = '0;
    bit          pend = 0;
    logic [15:0] lo_lat = '0;

    function automatic logic [31:0] make_frame(input logic [30:0] w, input logic even);
        int ones = 0;
        for (int i = 0; i < 31; i++) ones += w[i];
        return {(((ones % 2) == 0) ? 1'b1 : 1'b0) ^ even, w};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); md = 0; bn = 0; gp = 0; dv = 0; pend = 0; cur = '0;
        end else begin
            int  per;
            bit  tick, push, start;
            per   = div_slow ? 80 : 10;
            tick  = (dv >= per - 1);
            push  = ld_hi && pend && (q.size() < 8);
            start = 0;
            if (tick) begin
                if (md == 0) begin
                    if (tx_en && q.size() > 0) start = 1;
                end else if (md == 1) begin
                    if (bn == 31) begin md = 2; gp = 0; end
                    else bn++;
                end else begin
                    if (gp == 3) begin
                        if (tx_en && q.size() > 0) start = 1;
                        else md = 0;
                    end else gp++;
                end
            end
            if (start) begin
                cur = make_frame(q.pop_front(), par_even);
                md = 1; bn = 0;
            end
            if (push) q.push_back({bus[14:0], lo_lat});
            if (ld_lo) begin lo_lat = bus; pend = 1; end
            else if (ld_hi) pend = 0;
            dv = tick ? 0 : dv + 1;
        end
    end

    // ---------------- per-cycle comparison and line decoder ----------------
    int bits_seen = 0;
    int wpos = 0;
    int wones = 0;
    bit prev_act = 0;

    always @(posedge clk) begin
        #2;
        begin
            int  half;
            bit  e_one, e_zero, e_clk, e_rdy;
            half   = (div_slow ? 80 : 10) / 2;
            e_clk  = (dv < half);
            e_one  = (md == 1) && cur[bn] && (dv < half);
            e_zero = (md == 1) && !cur[bn] && (dv < half);
            e_rdy  = (q.size() == 0) && (md == 0);
            chk(tx_clk == e_clk, "R1", "tx_clk", tx_clk, e_clk);
            chk(line_one == e_one, "R6", "line_one", line_one, e_one);
            chk(line_zero == e_zero, "R6", "line_zero", line_zero, e_zero);
            chk(ready == e_rdy, "R4", "ready", ready, e_rdy);
            chk(lb_true == {line_one, line_zero}, "R11", "lb_true", lb_true, {line_one, line_zero});
            chk(lb_comp == {line_zero, line_one}, "R11", "lb_comp", lb_comp, {line_zero, line_one});
            chk(!(line_one && line_zero), "R8", "both lines", 1, 0);
        end
        if (!rst_n) begin
            wpos = 0; wones = 0; prev_act = 0;
        end else begin
            if ((line_one || line_zero) && !prev_act) begin
                bits_seen++; wpos++; wones += line_one;
                if (wpos == 32) begin
                    chk(((wones % 2) == 1) == !par_even, "R7", "frame ones", wones, par_even ? 0 : 1);
                    wpos = 0; wones = 0;
                end
            end
            prev_act = line_one || line_zero;
        end
    end

    // ---------------- stimulus ----------------
    task automatic load_word(input logic [15:0] lo, input logic [15:0] hi);
        @(negedge clk); bus = lo; ld_lo = 1'b1;
        @(negedge clk); ld_lo = 1'b0; bus = hi; ld_hi = 1'b1;
        @(negedge clk); ld_hi = 1'b0; bus = '0;
    endtask

    task automatic wait_ready(input int limit);
        int n = 0;
        while (!ready && n < limit) begin @(negedge clk); n++; end
        chk(ready == 1'b1, "R4", "ready after drain", ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int b0;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R9", "ready after reset", ready, 1);
        chk(!line_one && !line_zero, "R9", "lines after reset", line_one | line_zero, 0);

        // high half without low half is ignored
        @(negedge clk); bus = 16'h7fff; ld_hi = 1'b1;
        @(negedge clk); ld_hi = 1'b0; bus = '0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R2", "orphan high half", ready, 1);

        // single word, start latency
        load_word(16'hA5C3, 16'h8123);
        chk(ready == 1'b0, "R4", "ready after load", ready, 0);
        repeat (7) @(negedge clk);
        tx_en = 1'b1;
        n = 0;
        while (!(line_one || line_zero) && n < 200) begin @(negedge clk); n++; end
        chk(n >= 1 && n <= 11, "R5", "start latency", n, 10);
        wait_ready(1000);
        tx_en = 1'b0;

        // even parity, words loaded while enabled
        par_even = 1'b1;
        tx_en = 1'b1;
        load_word(16'hFFFF, 16'h7FFF);
        load_word(16'h0000, 16'h0000);
        load_word(16'h1234, 16'hC567);
        wait_ready(3000);
        tx_en = 1'b0;
        par_even = 1'b0;

        // overfill: nine offered, eight kept
        b0 = bits_seen;
        for (int i = 0; i < 9; i++) load_word(16'(i * 16'h1357 + 1), 16'(i * 16'h0ace));
        repeat (5) @(negedge clk);
        chk(ready == 1'b0, "R3", "full queue ready", ready, 0);
        tx_en = 1'b1;
        wait_ready(5000);
        tx_en = 1'b0;
        chk(bits_seen - b0 == 256, "R3", "bits sent from full queue", bits_seen - b0, 256);

        // enable removed mid-word
        b0 = bits_seen;
        load_word(16'h0F0F, 16'h3333);
        load_word(16'h5555, 16'h2AAA);
        load_word(16'h00FF, 16'h1F00);
        tx_en = 1'b1;
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        repeat (420) @(negedge clk);
        chk(bits_seen - b0 == 32, "R10", "bits after enable drop", bits_seen - b0, 32);
        chk(ready == 1'b0, "R10", "words left queued", ready, 0);

        // reset in the middle of a word
        tx_en = 1'b1;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R9", "ready in reset", ready, 1);
        chk(!line_one && !line_zero, "R9", "lines in reset", line_one | line_zero, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        b0 = bits_seen;
        repeat (400) @(negedge clk);
        chk(bits_seen == b0, "R9", "nothing sent after reset", bits_seen - b0, 0);
        chk(ready == 1'b1, "R9", "queue emptied", ready, 1);
        tx_en = 1'b0;

        // slow rate
        div_slow = 1'b1;
        repeat (3) @(negedge clk);
        b0 = bits_seen;
        load_word(16'hBEEF, 16'h4321);
        tx_en = 1'b1;
        wait_ready(6000);
        tx_en = 1'b0;
        chk(bits_seen - b0 == 32, "R1", "slow word bits", bits_seen - b0, 32);

        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule